// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 32-bit fixed-length instruction word into the field indices and control lines that an execute stage needs. It is purely combinational: the word presented on `instr` is split into its source, destination, shift-amount, immediate and jump-target fields, and the opcode (or, for the register format, the function code) is mapped onto a control bundle. That bundle covers register write, destination choice, ALU operand choice, ALU operation, memory read or write with access size, branch kind, jump kind and link.

Three layouts share the word. The register layout carries opcode, two source indices, a destination index, a shift amount and a function code. The immediate layout carries opcode, two register indices and a 16-bit constant. The jump layout carries opcode and a 26-bit word target. An encoding the decoder does not know raises `illegal` and leaves every side-effecting control low. The register file, the memory and the program-counter logic sit outside this block.

There is no clock and no stored state, so the notion of states and transitions reduces to a single combinational mapping from the instruction word to the outputs.

Top module: `instr_decoder`

## Requirements
- R1: Field positions are fixed. `src_a_idx` is bits 25..21, `src_b_idx` is bits 20..16, `shamt` is bits 10..6, `jump_target` is bits 25..0 and the opcode is bits 31..26.
- R2: Opcode 0 selects the register layout, and the function code in bits 5..0 picks the operation. Function 32 gives ADD (alu_op 0), 34 SUB (1), 36 AND (2), 37 OR (3), 39 NOR (4), 42 SLT (5), 0 SLL (6) and 2 SRL (7). Each of these writes the register named by bits 15..11 (dest_sel 1) and takes both ALU operands from registers (alu_src_imm 0).
- R3: Opcodes 8 (ADD), 10 (SLT), 12 (AND) and 13 (OR) take the ALU's second operand from the immediate and write the register named by bits 20..16 (dest_sel 0). The immediate is sign-extended for 8 and 10 and zero-extended for 12 and 13.
- R4: Opcode 15 writes the register named by bits 20..16 with alu_op 8. `imm_ext` then holds the 16-bit constant in bits 31..16 and zeros below.
- R5: Opcodes 32, 33 and 35 are loads of size byte (mem_size 0), half (1) and word (2). A load raises `mem_rd`, adds a sign-extended immediate (alu_op 0, alu_src_imm 1) and writes the register named by bits 20..16.
- R6: Opcodes 40, 41 and 43 are stores of size byte, half and word. A store raises `mem_wr`, adds a sign-extended immediate and never raises `reg_wr_en`.
- R7: Opcode 4 gives branch kind 1 (equal) and opcode 5 gives branch kind 2 (not equal). Both use alu_op 1 on two register operands, sign-extend the offset and write no register.
- R8: Opcode 2 gives jump kind 1 (direct) with no write. Opcode 3 gives jump kind 1, raises `link` and writes register 31 (dest_sel 2). Function 8 in the register layout gives jump kind 2 (register) with no write.
- R9: An opcode or function code not listed above raises `illegal`. In that case `reg_wr_en`, `mem_rd`, `mem_wr` and `link` are low, the branch and jump kinds are 0, alu_op is 0, dest_sel is 0 and mem_size is 2.
- R10: Register 0 always reads as zero, so `reg_wr_en` is never high when `dest_idx` is 0. All other controls keep their decoded values.
- R11: `mem_rd` and `mem_wr` are never high together, for any instruction word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| src_a_idx | output | 5 | First source register index |
| src_b_idx | output | 5 | Second source register index |
| dest_idx | output | 5 | Selected destination register index |
| shamt | output | 5 | Shift amount field |
| imm_ext | output | 32 | Extended immediate |
| jump_target | output | 26 | Word target of the jump layout |
| illegal | output | 1 | Unknown encoding |
| reg_wr_en | output | 1 | Register file write enable |
| dest_sel | output | 2 | Destination choice: 0 bits 20..16, 1 bits 15..11, 2 link register |
| alu_src_imm | output | 1 | Second ALU operand comes from the immediate |
| alu_op | output | 4 | ALU operation code |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| branch_kind | output | 2 | 0 none, 1 on equal, 2 on not equal |
| jump_kind | output | 2 | 0 none, 1 direct, 2 through register |
| link | output | 1 | Return address goes to the link register |

## Verification
The block holds no state, so a wrong mapping inside it shows at the ports in the same evaluation as the instruction that triggers it. The fault does not linger, and nothing that comes after it hides it. A mis-wired function-code row shows as a wrong `alu_op` or a missing write for exactly that encoding. A broken legality path shows as a write or memory access raised while `illegal` is high. A wrong extension mode shows in the upper half of `imm_ext`. For this reason the bench drives each encoding class, including the unknown ones and the register-0 destinations, and compares the whole control bundle for each word.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

    localparam int INSN_W  = 32;
    localparam int OP_W    = 6;
    localparam int RIDX_W  = 5;
    localparam int FUNCT_W = 6;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
        ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] { SZ_BYTE = 2'd0, SZ_HALF, SZ_WORD } mem_size_e;
    typedef enum logic [1:0] { BR_NONE = 2'd0, BR_EQ, BR_NE } branch_e;
    typedef enum logic [1:0] { JMP_NONE = 2'd0, JMP_DIRECT, JMP_REG } jump_e;
    typedef enum logic [1:0] { DST_RT = 2'd0, DST_RD, DST_LINK } dest_sel_e;
    typedef enum logic [1:0] { EXT_SIGN = 2'd0, EXT_ZERO, EXT_UPPER } ext_e;

    typedef struct packed {
        logic      reg_wr;
        dest_sel_e dest_sel;
        logic      alu_src_imm;
        alu_op_e   alu_op;
        logic      mem_rd;
        logic      mem_wr;
        mem_size_e mem_size;
        branch_e   branch;
        jump_e     jump;
        logic      link;
        ext_e      ext;
    } ctrl_t;

    localparam logic [OP_W-1:0] OP_RFMT = 6'd0;
    localparam logic [OP_W-1:0] OP_J    = 6'd2;
    localparam logic [OP_W-1:0] OP_JAL  = 6'd3;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'd4;
    localparam logic [OP_W-1:0] OP_BNE  = 6'd5;
    localparam logic [OP_W-1:0] OP_ADDI = 6'd8;
    localparam logic [OP_W-1:0] OP_SLTI = 6'd10;
    localparam logic [OP_W-1:0] OP_ANDI = 6'd12;
    localparam logic [OP_W-1:0] OP_ORI  = 6'd13;
    localparam logic [OP_W-1:0] OP_LUI  = 6'd15;
    localparam logic [OP_W-1:0] OP_LB   = 6'd32;
    localparam logic [OP_W-1:0] OP_LH   = 6'd33;
    localparam logic [OP_W-1:0] OP_LW   = 6'd35;
    localparam logic [OP_W-1:0] OP_SB   = 6'd40;
    localparam logic [OP_W-1:0] OP_SH   = 6'd41;
    localparam logic [OP_W-1:0] OP_SW   = 6'd43;

    localparam logic [FUNCT_W-1:0] FN_SLL = 6'd0;
    localparam logic [FUNCT_W-1:0] FN_SRL = 6'd2;
    localparam logic [FUNCT_W-1:0] FN_JR  = 6'd8;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'd36;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'd37;
    localparam logic [FUNCT_W-1:0] FN_NOR = 6'd39;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

    function automatic ctrl_t idle_ctrl();
        ctrl_t c;
        c.reg_wr      = 1'b0;
        c.dest_sel    = DST_RT;
        c.alu_src_imm = 1'b0;
        c.alu_op      = ALU_ADD;
        c.mem_rd      = 1'b0;
        c.mem_wr      = 1'b0;
        c.mem_size    = SZ_WORD;
        c.branch      = BR_NONE;
        c.jump        = JMP_NONE;
        c.link        = 1'b0;
        c.ext         = EXT_SIGN;
        return c;
    endfunction

endpackage

// File: rtl/instr_field_split.sv
module instr_field_split
    import instr_dec_pkg::*;
(
    input  logic [INSN_W-1:0]  instr,
    output logic [OP_W-1:0]    op,
    output logic [RIDX_W-1:0]  rs,
    output logic [RIDX_W-1:0]  rt,
    output logic [RIDX_W-1:0]  rd,
    output logic [RIDX_W-1:0]  sh,
    output logic [FUNCT_W-1:0] funct,
    output logic [IMM_W-1:0]   imm,
    output logic [TGT_W-1:0]   target
);
    localparam int OP_LSB = INSN_W - OP_W;
    localparam int RS_LSB = OP_LSB - RIDX_W;
    localparam int RT_LSB = RS_LSB - RIDX_W;
    localparam int RD_LSB = RT_LSB - RIDX_W;
    localparam int SH_LSB = RD_LSB - RIDX_W;

    assign op     = instr[OP_LSB +: OP_W];
    assign rs     = instr[RS_LSB +: RIDX_W];
    assign rt     = instr[RT_LSB +: RIDX_W];
    assign rd     = instr[RD_LSB +: RIDX_W];
    assign sh     = instr[SH_LSB +: RIDX_W];
    assign funct  = instr[0 +: FUNCT_W];
    assign imm    = instr[0 +: IMM_W];
    assign target = instr[0 +: TGT_W];
endmodule

// File: rtl/rfmt_decoder.sv
module rfmt_decoder
    import instr_dec_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct,
    output ctrl_t              ctrl,
    output logic               legal
);
    always_comb begin
        ctrl          = idle_ctrl();
        ctrl.reg_wr   = 1'b1;
        ctrl.dest_sel = DST_RD;
        legal         = 1'b1;
        unique case (funct)
            FN_ADD:  ctrl.alu_op = ALU_ADD;
            FN_SUB:  ctrl.alu_op = ALU_SUB;
            FN_AND:  ctrl.alu_op = ALU_AND;
            FN_OR:   ctrl.alu_op = ALU_OR;
            FN_NOR:  ctrl.alu_op = ALU_NOR;
            FN_SLT:  ctrl.alu_op = ALU_SLT;
            FN_SLL:  ctrl.alu_op = ALU_SLL;
            FN_SRL:  ctrl.alu_op = ALU_SRL;
            FN_JR: begin
                ctrl.reg_wr = 1'b0;
                ctrl.jump   = JMP_REG;
            end
            default: begin
                ctrl  = idle_ctrl();
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/opcode_decoder.sv
module opcode_decoder
    import instr_dec_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  ctrl_t           rfmt_ctrl,
    input  logic            rfmt_legal,
    output ctrl_t           ctrl,
    output logic            legal
);
    always_comb begin
        ctrl  = idle_ctrl();
        legal = 1'b1;
        unique case (op)
            OP_RFMT: begin
                ctrl  = rfmt_ctrl;
                legal = rfmt_legal;
            end
            OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_LUI: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.alu_src_imm = 1'b1;
                unique case (op)
                    OP_SLTI: ctrl.alu_op = ALU_SLT;
                    OP_ANDI: begin ctrl.alu_op = ALU_AND; ctrl.ext = EXT_ZERO;  end
                    OP_ORI:  begin ctrl.alu_op = ALU_OR;  ctrl.ext = EXT_ZERO;  end
                    OP_LUI:  begin ctrl.alu_op = ALU_LUI; ctrl.ext = EXT_UPPER; end
                    default: ctrl.alu_op = ALU_ADD;
                endcase
            end
            OP_LB, OP_LH, OP_LW: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.mem_size    = (op == OP_LB) ? SZ_BYTE :
                                   (op == OP_LH) ? SZ_HALF : SZ_WORD;
            end
            OP_SB, OP_SH, OP_SW: begin
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_wr      = 1'b1;
                ctrl.mem_size    = (op == OP_SB) ? SZ_BYTE :
                                   (op == OP_SH) ? SZ_HALF : SZ_WORD;
            end
            OP_BEQ, OP_BNE: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.branch = (op == OP_BEQ) ? BR_EQ : BR_NE;
            end
            OP_J: ctrl.jump = JMP_DIRECT;
            OP_JAL: begin
                ctrl.jump     = JMP_DIRECT;
                ctrl.link     = 1'b1;
                ctrl.reg_wr   = 1'b1;
                ctrl.dest_sel = DST_LINK;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/imm_extender.sv
module imm_extender
    import instr_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  ext_e              mode,
    output logic [DATA_W-1:0] imm_ext
);
    localparam int FILL_W = DATA_W - IMM_W;

    always_comb begin
        unique case (mode)
            EXT_ZERO:  imm_ext = {{FILL_W{1'b0}}, imm};
            EXT_UPPER: imm_ext = {imm, {FILL_W{1'b0}}};
            default:   imm_ext = {{FILL_W{imm[IMM_W-1]}}, imm};
        endcase
    end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import instr_dec_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LINK_IDX = 31
) (
    input  logic [31:0] instr,
    output logic [4:0]  src_a_idx,
    output logic [4:0]  src_b_idx,
    output logic [4:0]  dest_idx,
    output logic [4:0]  shamt,
    output logic [31:0] imm_ext,
    output logic [25:0] jump_target,
    output logic        illegal,
    output logic        reg_wr_en,
    output logic [1:0]  dest_sel,
    output logic        alu_src_imm,
    output logic [3:0]  alu_op,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [1:0]  mem_size,
    output logic [1:0]  branch_kind,
    output logic [1:0]  jump_kind,
    output logic        link
);
    logic [OP_W-1:0]    f_op;
    logic [RIDX_W-1:0]  f_rs, f_rt, f_rd, f_sh;
    logic [FUNCT_W-1:0] f_funct;
    logic [IMM_W-1:0]   f_imm;
    logic [TGT_W-1:0]   f_tgt;
    ctrl_t              rfmt_ctrl, ctrl;
    logic               rfmt_legal, op_legal;

    instr_field_split i_split (
        .instr (instr), .op (f_op), .rs (f_rs), .rt (f_rt), .rd (f_rd),
        .sh (f_sh), .funct (f_funct), .imm (f_imm), .target (f_tgt)
    );

    rfmt_decoder i_rfmt (
        .funct (f_funct), .ctrl (rfmt_ctrl), .legal (rfmt_legal)
    );

    opcode_decoder i_opdec (
        .op (f_op), .rfmt_ctrl (rfmt_ctrl), .rfmt_legal (rfmt_legal),
        .ctrl (ctrl), .legal (op_legal)
    );

    imm_extender #(.DATA_W (DATA_W)) i_ext (
        .imm (f_imm), .mode (ctrl.ext), .imm_ext (imm_ext)
    );

    always_comb begin
        unique case (ctrl.dest_sel)
            DST_RD:   dest_idx = f_rd;
            DST_LINK: dest_idx = RIDX_W'(LINK_IDX);
            default:  dest_idx = f_rt;
        endcase
    end

    assign src_a_idx   = f_rs;
    assign src_b_idx   = f_rt;
    assign shamt       = f_sh;
    assign jump_target = f_tgt;
    assign illegal     = ~op_legal;
    assign reg_wr_en   = ctrl.reg_wr && (dest_idx != '0);
    assign dest_sel    = ctrl.dest_sel;
    assign alu_src_imm = ctrl.alu_src_imm;
    assign alu_op      = ctrl.alu_op;
    assign mem_rd      = ctrl.mem_rd;
    assign mem_wr      = ctrl.mem_wr;
    assign mem_size    = ctrl.mem_size;
    assign branch_kind = ctrl.branch;
    assign jump_kind   = ctrl.jump;
    assign link        = ctrl.link;
endmodule

// File: rtl/instr_decoder_checker.sv
module instr_decoder_checker (
    input logic [31:0] instr,
    input logic [4:0]  dest_idx,
    input logic        illegal,
    input logic        reg_wr_en,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [1:0]  branch_kind,
    input logic [1:0]  jump_kind,
    input logic        link
);
    always_comb begin
        assert_rw_exclusive_R11: assert (!(mem_rd && mem_wr))
            else $error("memory read and write raised together for %h", instr);
        assert_illegal_quiet_R9: assert (!illegal ||
            (!reg_wr_en && !mem_rd && !mem_wr && !link &&
             branch_kind == 2'd0 && jump_kind == 2'd0))
            else $error("illegal word %h still drives a side effect", instr);
        assert_no_zero_write_R10: assert (!reg_wr_en || dest_idx != 5'd0)
            else $error("write to register 0 for %h", instr);
        assert_link_target_R8: assert (!link ||
            (dest_idx == 5'd31 && reg_wr_en && jump_kind == 2'd1))
            else $error("link without register 31 write for %h", instr);
        assert_store_no_write_R6: assert (!mem_wr || !reg_wr_en)
            else $error("store also writes a register for %h", instr);
    end
endmodule

bind instr_decoder instr_decoder_checker i_checker (
    .instr       (instr),
    .dest_idx    (dest_idx),
    .illegal     (illegal),
    .reg_wr_en   (reg_wr_en),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .branch_kind (branch_kind),
    .jump_kind   (jump_kind),
    .link        (link)
);

// File: tb/test_instr_decoder.sv
module test_instr_decoder;

    function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] jtype(int op, int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    // packed control: ill, wr, dsel(2), dest(5), src, alu(4), mrd, mwr, size(2), br(2), jmp(2), link
    function automatic logic [22:0] mk(int ill, int wr, int dsel, int dest, int src, int alu,
                                       int mrd, int mwr, int sz, int br, int jmp, int lnk);
        return {1'(ill), 1'(wr), 2'(dsel), 5'(dest), 1'(src), 4'(alu),
                1'(mrd), 1'(mwr), 2'(sz), 2'(br), 2'(jmp), 1'(lnk)};
    endfunction

    function automatic logic [62:0] vec(int tag, logic [31:0] w, logic [22:0] c);
        return {8'(tag), w, c};
    endfunction

    localparam int NVEC = 32;
    localparam logic [62:0] VECS [NVEC] = '{
        vec(2,  32'h00AF8020,            mk(0,1,1,16,0,0,0,0,2,0,0,0)), // R2 add
        vec(2,  rtype(1,2,3,0,34),       mk(0,1,1,3,0,1,0,0,2,0,0,0)),  // R2 sub
        vec(2,  rtype(1,2,4,0,36),       mk(0,1,1,4,0,2,0,0,2,0,0,0)),  // R2 and
        vec(2,  rtype(1,2,5,0,37),       mk(0,1,1,5,0,3,0,0,2,0,0,0)),  // R2 or
        vec(2,  rtype(1,2,6,0,39),       mk(0,1,1,6,0,4,0,0,2,0,0,0)),  // R2 nor
        vec(2,  rtype(1,2,7,0,42),       mk(0,1,1,7,0,5,0,0,2,0,0,0)),  // R2 slt
        vec(2,  rtype(0,16,10,4,0),      mk(0,1,1,10,0,6,0,0,2,0,0,0)), // R2 sll
        vec(2,  rtype(0,16,11,3,2),      mk(0,1,1,11,0,7,0,0,2,0,0,0)), // R2 srl
        vec(8,  rtype(31,0,0,0,8),       mk(0,0,1,0,0,0,0,0,2,0,2,0)),  // R8 jr
        vec(3,  itype(8,19,19,1),        mk(0,1,0,19,1,0,0,0,2,0,0,0)), // R3 addi
        vec(3,  itype(10,2,9,10),        mk(0,1,0,9,1,5,0,0,2,0,0,0)),  // R3 slti
        vec(3,  itype(12,17,17,100),     mk(0,1,0,17,1,2,0,0,2,0,0,0)), // R3 andi
        vec(3,  itype(13,17,18,100),     mk(0,1,0,18,1,3,0,0,2,0,0,0)), // R3 ori
        vec(4,  itype(15,0,8,255),       mk(0,1,0,8,1,8,0,0,2,0,0,0)),  // R4 lui
        vec(5,  itype(35,19,8,32),       mk(0,1,0,8,1,0,1,0,2,0,0,0)),  // R5 lw
        vec(5,  itype(33,19,12,2),       mk(0,1,0,12,1,0,1,0,1,0,0,0)), // R5 lh
        vec(5,  itype(32,19,13,1),       mk(0,1,0,13,1,0,1,0,0,0,0,0)), // R5 lb
        vec(6,  itype(43,19,8,48),       mk(0,0,0,8,1,0,0,1,2,0,0,0)),  // R6 sw
        vec(6,  itype(41,19,8,6),        mk(0,0,0,8,1,0,0,1,1,0,0,0)),  // R6 sh
        vec(6,  itype(40,19,8,3),        mk(0,0,0,8,1,0,0,1,0,0,0,0)),  // R6 sb
        vec(7,  itype(4,16,17,2),        mk(0,0,0,17,0,1,0,0,2,1,0,0)), // R7 beq
        vec(7,  itype(5,8,21,2),         mk(0,0,0,21,0,1,0,0,2,2,0,0)), // R7 bne
        vec(8,  jtype(2,20000),          mk(0,0,0,0,0,0,0,0,2,0,1,0)),  // R8 j
        vec(8,  jtype(3,32'h0123456),    mk(0,1,2,31,0,0,0,0,2,0,1,1)), // R8 jal
        vec(9,  itype(63,1,2,5),         mk(1,0,0,2,0,0,0,0,2,0,0,0)),  // R9 bad opcode
        vec(9,  itype(1,3,4,0),          mk(1,0,0,4,0,0,0,0,2,0,0,0)),  // R9 bad opcode
        vec(9,  rtype(1,2,3,0,1),        mk(1,0,0,2,0,0,0,0,2,0,0,0)),  // R9 bad funct
        vec(9,  rtype(4,5,6,0,63),       mk(1,0,0,5,0,0,0,0,2,0,0,0)),  // R9 bad funct
        vec(10, rtype(1,2,0,0,32),       mk(0,0,1,0,0,0,0,0,2,0,0,0)),  // R10 add to r0
        vec(10, itype(8,1,0,7),          mk(0,0,0,0,1,0,0,0,2,0,0,0)),  // R10 addi to r0
        vec(10, itype(35,1,0,4),         mk(0,0,0,0,1,0,1,0,2,0,0,0)),  // R10 lw to r0
        vec(10, rtype(0,0,0,0,0),        mk(0,0,1,0,0,6,0,0,2,0,0,0))   // R10 all-zero word
    };

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  src_a_idx, src_b_idx, dest_idx, shamt;
    logic [31:0] imm_ext;
    logic [25:0] jump_target;
    logic        illegal, reg_wr_en, alu_src_imm, mem_rd, mem_wr, link;
    logic [1:0]  dest_sel, mem_size, branch_kind, jump_kind;
    logic [3:0]  alu_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    instr_decoder i_instr_decoder (
        .instr (instr), .src_a_idx (src_a_idx), .src_b_idx (src_b_idx),
        .dest_idx (dest_idx), .shamt (shamt), .imm_ext (imm_ext),
        .jump_target (jump_target), .illegal (illegal), .reg_wr_en (reg_wr_en),
        .dest_sel (dest_sel), .alu_src_imm (alu_src_imm), .alu_op (alu_op),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_size (mem_size),
        .branch_kind (branch_kind), .jump_kind (jump_kind), .link (link)
    );

    function automatic logic [22:0] observed();
        return {illegal, reg_wr_en, dest_sel, dest_idx, alu_src_imm, alu_op,
                mem_rd, mem_wr, mem_size, branch_kind, jump_kind, link};
    endfunction

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        #1 instr = w;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s word=%h got=%h exp=%h", req, instr, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // table walk over every encoding class
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][54:23]);
            check($sformatf("R%0d control", int'(VECS[i][62:55])),
                  32'(observed()), 32'(VECS[i][22:0]));
        end

        // R1: field positions on the example word and on a shift
        apply(32'h00AF8020);
        check("R1 src_a", 32'(src_a_idx), 32'd5);
        check("R1 src_b", 32'(src_b_idx), 32'd15);
        apply(rtype(0,16,10,4,0));
        check("R1 shamt", 32'(shamt), 32'd4);
        apply(jtype(2,20000));
        check("R1 target", 32'(jump_target), 32'd20000);

        // R3: sign versus zero extension
        apply(itype(8,1,2,16'hFFFC));
        check("R3 addi sign", imm_ext, 32'hFFFF_FFFC);
        apply(itype(12,1,2,16'hFFFC));
        check("R3 andi zero", imm_ext, 32'h0000_FFFC);
        apply(itype(10,1,2,16'h8001));
        check("R3 slti sign", imm_ext, 32'hFFFF_8001);

        // R4: upper placement
        apply(itype(15,0,8,255));
        check("R4 lui imm", imm_ext, 32'h00FF_0000);

        // R5 and R7: negative offsets
        apply(itype(35,1,2,16'h8000));
        check("R5 load offset", imm_ext, 32'hFFFF_8000);
        apply(itype(4,1,2,16'hFFFF));
        check("R7 branch offset", imm_ext, 32'hFFFF_FFFF);

        // R11: sweep every opcode, no word may read and write at once
        begin
            int both = 0;
            for (int op = 0; op < 64; op++) begin
                apply(itype(op, 3, 4, 16'h0020));
                if (mem_rd && mem_wr) both++;
            end
            check("R11 rd/wr overlap", 32'(both), 32'd0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule